// File: doc/BRIEF.md
# Repeating Status Byte Serializer

This block drives the serial data line of a serial memory controller's slave port while a host is reading the device status. An upstream command decoder pulses `start` in the system clock cycle in which it captures the last bit of the status-read command. From the next cycle on, this block presents the status byte one bit at a time, most significant bit first. It advances one bit on each falling serial-clock edge, which arrives as a one-cycle strobe already synchronised to the system clock. After the least significant bit it starts over at the top bit, and it keeps doing so for as long as the host holds the device selected.

The top bit is the ready flag, the inverse of the sequencer's busy signal. It is never latched: while it is on the line it follows busy live. A host can therefore stop the serial clock on that bit and watch the line go from 0 to 1 when the internal operation ends. The compare-mismatch flag is captured once per repetition, at the start of every pass through the byte, so a single pass never mixes old and new values. The remaining six bits are constants. Releasing the select line turns the output driver off and returns the bit position to the top.

Top module: `stat_shifter`

## Requirements
- R1: While `rst` is high and after it falls, with no `start` yet, `sdo_en` is 0 and `sdo` is 0.
- R2: `start` seen with `sel_n` low makes `sdo_en` 1 from the next cycle, with the bit-7 position selected.
- R3: While bit 7 is selected, `sdo` equals the inverse of `busy` in the same cycle, even when no serial clock edge arrives.
- R4: Bit 6 is the value of `cmp_miss` captured at the cycle that entered bit 7 (a `start` or a wrap). Later changes of `cmp_miss` do not reach `sdo` until the next pass.
- R5: Bits 5, 4 and 3 are sent as 0, 0, 1. Bits 2, 1 and 0 are sent as 0.
- R6: Each `sck_fall` strobe while active moves to the next lower bit. Bits go out in the order 7 down to 0. Without a strobe the position holds.
- R7: An `sck_fall` strobe on bit 0 returns to bit 7 and takes a new capture of `cmp_miss`.
- R8: `sel_n` high clears `sdo_en` from the next cycle. A later `start` begins again at bit 7, whatever bit was interrupted.
- R9: `start` has no effect while `sel_n` is high.
- R10: `sck_fall` strobes while inactive have no effect: the output stays disabled, and the next `start` still begins at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Slave select, active low |
| start | input | 1 | One-cycle pulse: the status-read command has been decoded |
| sck_fall | input | 1 | One-cycle pulse per falling serial-clock edge |
| busy | input | 1 | Live busy flag from the sequencer |
| cmp_miss | input | 1 | Latest page compare result, 1 = mismatch |
| sdo | output | 1 | Serial data bit (0 when disabled) |
| sdo_en | output | 1 | Output driver enable. 0 means the line is high impedance |

## Verification
A full pass through the byte is walked with the compare flag changed between captures. This shows whether bit 6 holds its capture and the constant bits come out in place. The clock is paused on bit 7 while busy drops, which separates a live ready bit from a latched one. The pass continues across the wrap with busy and compare changed again, which shows whether a fresh capture is taken at each wrap. Further patterns deselect in the middle of a byte, and send `start` or clock strobes while deselected. These check that the position restarts at bit 7 and that inputs are ignored while the output is off.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int          STAT_BITS    = 8;
    localparam logic [2:0]  DENSITY_CODE = 3'b001;
    localparam logic [2:0]  RSVD_CODE    = 3'b000;

    typedef struct packed {
        logic       ready;
        logic       mismatch;
        logic [2:0] density;
        logic [2:0] rsvd;
    } status_t;

    function automatic status_t pack_status(input logic ready, input logic mismatch);
        status_t s;
        s.ready    = ready;
        s.mismatch = mismatch;
        s.density  = DENSITY_CODE;
        s.rsvd     = RSVD_CODE;
        return s;
    endfunction

endpackage

// File: rtl/stat_bitctr.sv
module stat_bitctr #(
    parameter int NBITS = status_pkg::STAT_BITS,
    localparam int IW   = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_n,
    input  logic          start,
    input  logic          sck_fall,
    output logic          active,
    output logic [IW-1:0] idx,
    output logic          reload,
    output logic          wrap
);
    localparam logic [IW-1:0] TOP = IW'(NBITS - 1);

    assign reload = start & ~sel_n;
    assign wrap   = active & ~sel_n & ~start & sck_fall & (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= TOP;
        end else if (sel_n) begin
            active <= 1'b0;
            idx    <= TOP;
        end else if (start) begin
            active <= 1'b1;
            idx    <= TOP;
        end else if (active && sck_fall) begin
            idx <= (idx == '0) ? TOP : idx - 1'b1;
        end
    end

    // R2: a decoded start selects the top bit
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (start && !sel_n) |=> (active && idx == TOP));
    // R8: deselect turns off and rewinds
    a_r8_desel: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (!active && idx == TOP));
    // R6: strobe steps down by one
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (active && !sel_n && !start && sck_fall && idx != '0) |=> (idx == $past(idx) - 1'b1));
    // R6: no strobe, position holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (active && !sel_n && !start && !sck_fall) |=> $stable(idx));
    // R10: inactive implies parked at top bit
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !active |-> (idx == TOP));

endmodule

// File: rtl/stat_snap.sv
module stat_snap (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic cmp_in,
    output logic cmp_q
);
    always_ff @(posedge clk) begin
        if (rst)       cmp_q <= 1'b0;
        else if (load) cmp_q <= cmp_in;
    end

    // R4: captured flag holds between captures
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cmp_q));
    // R7: each capture takes the current compare value
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (cmp_q == $past(cmp_in)));

endmodule

// File: rtl/stat_shifter.sv
module stat_shifter (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic start,
    input  logic sck_fall,
    input  logic busy,
    input  logic cmp_miss,
    output logic sdo,
    output logic sdo_en
);
    import status_pkg::*;

    localparam int IW = $clog2(STAT_BITS);
    localparam logic [IW-1:0] TOP = IW'(STAT_BITS - 1);

    logic          active;
    logic [IW-1:0] idx;
    logic          reload;
    logic          wrap;
    logic          cmp_q;
    status_t       stat;
    logic [STAT_BITS-1:0] stat_bits;

    stat_bitctr #(.NBITS(STAT_BITS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (sel_n),
        .start    (start),
        .sck_fall (sck_fall),
        .active   (active),
        .idx      (idx),
        .reload   (reload),
        .wrap     (wrap)
    );

    stat_snap u_snap (
        .clk    (clk),
        .rst    (rst),
        .load   (reload | wrap),
        .cmp_in (cmp_miss),
        .cmp_q  (cmp_q)
    );

    always_comb begin
        stat      = pack_status(~busy, cmp_q);
        stat_bits = stat;
        sdo_en    = active;
        if (!active)         sdo = 1'b0;
        else if (idx == TOP) sdo = ~busy;
        else                 sdo = stat_bits[idx];
    end

    // R1: disabled output is quiet
    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |-> !sdo);
    // R5: fixed density bit 3 is one
    a_r5_density_one: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && idx == IW'(3)) |-> sdo);
    // R5: other constant positions are zero
    a_r5_zeros: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && idx != TOP && idx != IW'(6) && idx != IW'(3)) |-> !sdo);

endmodule

// File: tb/tb_stat_shifter.sv
module tb_stat_shifter;

    logic clk = 1'b0;
    logic rst, sel_n, start, sck_fall, busy, cmp_miss;
    logic sdo, sdo_en;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    stat_shifter dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .start(start),
        .sck_fall(sck_fall), .busy(busy), .cmp_miss(cmp_miss),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    // {busy, cmp_miss, sck_fall, expected sdo}; sdo_en expected 1 throughout
    localparam logic [3:0] VEC [13] = '{
        4'b1_0_0_0, // 0  R3 paused on bit 7, busy -> 0; R4 cmp change ignored
        4'b0_0_0_1, // 1  R3 busy drops, line follows live
        4'b0_0_1_1, // 2  R4 bit 6 keeps capture 1; R6 step
        4'b0_0_1_0, // 3  R5 bit 5
        4'b0_0_1_0, // 4  R5 bit 4
        4'b0_0_1_1, // 5  R5 bit 3
        4'b0_0_1_0, // 6  R5 bit 2
        4'b0_0_1_0, // 7  R5 bit 1
        4'b1_0_1_0, // 8  R5 bit 0
        4'b1_0_0_0, // 9  R6 no strobe, hold bit 0
        4'b1_0_1_0, // 10 R7 wrap to bit 7, capture cmp=0
        4'b1_1_1_0, // 11 R7 bit 6 shows new capture 0
        4'b1_1_1_0  // 12 R5 bit 5
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s_n, input logic st, input logic f);
        sel_n = s_n; start = st; sck_fall = f;
        @(posedge clk);
        @(negedge clk);
        #0.5;
        start = 1'b0; sck_fall = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sel_n = 1'b1; start = 1'b0; sck_fall = 1'b0;
        busy = 1'b1; cmp_miss = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 en in reset", sdo_en, 1'b0);
        rst = 1'b0;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R1 en after reset", sdo_en, 1'b0);
        chk("R1 sdo after reset", sdo, 1'b0);

        // R2: start with busy=1, cmp=1
        cyc(1'b0, 1'b1, 1'b0);
        chk("R2 enable", sdo_en, 1'b1);
        chk("R2 bit7 busy", sdo, 1'b0);

        for (int i = 0; i < 13; i++) begin
            busy     = VEC[i][3];
            cmp_miss = VEC[i][2];
            cyc(1'b0, 1'b0, VEC[i][1]);
            chk($sformatf("R3/R4/R5/R6/R7 vector %0d en", i), sdo_en, 1'b1);
            chk($sformatf("R3/R4/R5/R6/R7 vector %0d sdo", i), sdo, VEC[i][0]);
        end

        // R8: deselect mid-byte
        cyc(1'b1, 1'b0, 1'b0);
        chk("R8 deselect en", sdo_en, 1'b0);
        chk("R8 deselect sdo", sdo, 1'b0);
        // R9: start while deselected
        cyc(1'b1, 1'b1, 1'b0);
        chk("R9 start ignored", sdo_en, 1'b0);
        // R10: strobe while selected but inactive
        cyc(1'b0, 1'b0, 1'b1);
        chk("R10 strobe ignored", sdo_en, 1'b0);
        // R8/R10: restart at bit 7
        busy = 1'b0; cmp_miss = 1'b1;
        cyc(1'b0, 1'b1, 1'b0);
        chk("R8 restart en", sdo_en, 1'b1);
        chk("R8 restart bit7 ready", sdo, 1'b1);
        cmp_miss = 1'b0;
        cyc(1'b0, 1'b0, 1'b1);
        chk("R10 bit6 after restart", sdo, 1'b1);
        busy = 1'b1;
        cyc(1'b0, 1'b0, 1'b1);
        chk("R5 bit5 after restart", sdo, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule